// File: doc/BRIEF.md
# Two-Precision Significand Rounder

This block takes an unrounded floating-point significand and rounds it to double or single precision. The significand is 64 bits wide and normalized, with its leading one at bit 54. Bits 63:55 are zero on entry. For double precision the kept part runs from bit 54 down to bit 2. For single precision it runs from bit 54 down to bit 31. A separate sticky input stands for any nonzero bits that were already lost below bit 0.

A one-cycle `start` pulse captures the operands. In the next step the block decides on the rounding, adds one unit in the last place when it rounds up, and clears every discarded bit. One cycle after that, it shifts right by one if the increment carried past bit 54, and it raises the exponent to match. A `done` pulse marks the result. The result and both flags then stay unchanged until the next `start` completes.

The increment is a fixed constant with a one at one of two positions, chosen by the precision. The clearing of discarded bits uses the same two-way choice, so no variable-width mask logic is needed.

Top module: `fp_round_unit`

## Requirements
- R1: In double precision, a round-up adds one at bit 2 of the significand.
- R2: In single precision, a round-up adds one at bit 31 of the significand.
- R3: Bits 1 and 0 of the result are always zero.
- R4: In single precision, bits 30 down to 2 of the result are also zero.
- R5: When `mode_in` is 00 (round to nearest, ties to even), the block rounds up in two cases. The first is when the discarded part, with the sticky bit, is more than half a unit in the last place. The second is when it is exactly half and the kept LSB (bit 2 for double, bit 31 for single) is 1.
- R6: When `mode_in` is 01 (round toward zero), the block never rounds up.
- R7: When `mode_in` is 10 (toward +infinity), the block rounds up only for a positive sign (`sign_in` = 0) with an inexact value. When `mode_in` is 11 (toward -infinity), it rounds up only for a negative sign (`sign_in` = 1) with an inexact value.
- R8: `inexact` is 1 exactly when some discarded bit or the sticky bit is set, whether or not a round-up happens. `rounded_up` reports whether a round-up happened.
- R9: If the increment makes bit 55 a one, the result is shifted right by one and `exp_out` equals `exp_in` + 1. Otherwise `exp_out` equals `exp_in`. The flags are not affected by the shift.
- R10: `done` is high for exactly one cycle, two cycles after the cycle in which `start` was high.
- R11: Between results, `sig_out`, `exp_out`, `rounded_up` and `inexact` hold their values, even when the data inputs change while `start` is low.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Captures the operands |
| sig_in | input | 64 | Unrounded significand, leading one at bit 54 |
| sticky_in | input | 1 | OR of the bits already lost below bit 0 |
| single_in | input | 1 | 1 selects single precision, 0 selects double |
| mode_in | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sign_in | input | 1 | Sign of the result |
| exp_in | input | EXP_W | Exponent before rounding |
| sig_out | output | 64 | Rounded significand |
| exp_out | output | EXP_W | Exponent after rounding |
| rounded_up | output | 1 | A round-up occurred |
| inexact | output | 1 | Discarded bits or the sticky bit were nonzero |
| done | output | 1 | Result valid pulse |

## Verification
A wrong round decision shows up in the next `done` cycle as a significand off by one unit in the last place, together with a wrong `rounded_up` flag. A wrong increment position or a bad clearing step leaves stray ones below the kept LSB in that same cycle. A missed renormalization shows as bit 55 set with an unchanged exponent. The bench sweeps every guard, round and sticky combination against each mode, sign and precision. It also feeds an all-ones significand to force the carry, so each of these faults is caught at the first result that depends on it.

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int EXP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      sig_in,
  input  logic             sticky_in,
  input  logic             single_in,
  input  logic [1:0]       mode_in,
  input  logic             sign_in,
  input  logic [EXP_W-1:0] exp_in,
  output logic [63:0]      sig_out,
  output logic [EXP_W-1:0] exp_out,
  output logic             rounded_up,
  output logic             inexact,
  output logic             done
);

  logic        guard, rest, lsb, loose, up;
  logic [63:0] inc, raw, trimmed;

  assign guard = single_in ? sig_in[30] : sig_in[1];
  assign rest  = sticky_in | (single_in ? |sig_in[29:0] : sig_in[0]);
  assign lsb   = single_in ? sig_in[31] : sig_in[2];
  assign loose = guard | rest;

  always_comb begin
    case (mode_in)
      2'b00:   up = guard & (rest | lsb);
      2'b01:   up = 1'b0;
      2'b10:   up = loose & ~sign_in;
      default: up = loose & sign_in;
    endcase
  end

  assign inc     = single_in ? (64'd1 << 31) : (64'd1 << 2);
  assign raw     = sig_in + (up ? inc : 64'd0);
  assign trimmed = {raw[63:31], single_in ? 29'd0 : raw[30:2], 2'b00};

  logic [63:0]      s1_sig;
  logic [EXP_W-1:0] s1_exp;
  logic             s1_up, s1_inx, s1_single, v1, out_single;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; s1_sig <= '0; s1_exp <= '0;
      s1_up <= 1'b0; s1_inx <= 1'b0; s1_single <= 1'b0;
    end else begin
      v1 <= start;
      if (start) begin
        s1_sig <= trimmed; s1_exp <= exp_in;
        s1_up <= up; s1_inx <= loose; s1_single <= single_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; sig_out <= '0; exp_out <= '0;
      rounded_up <= 1'b0; inexact <= 1'b0; out_single <= 1'b0;
    end else begin
      done <= v1;
      if (v1) begin
        sig_out    <= s1_sig[55] ? (s1_sig >> 1) : s1_sig;
        exp_out    <= s1_sig[55] ? s1_exp + 1'b1 : s1_exp;
        rounded_up <= s1_up;
        inexact    <= s1_inx;
        out_single <= s1_single;
      end
    end
  end

  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sig_out[1:0] == 2'b00); // R3
  AST_SGL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && out_single) |-> sig_out[30:2] == 29'd0); // R4
  AST_UP_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rounded_up) |-> inexact); // R8
  AST_DONE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 done); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(v1) |-> ($stable(sig_out) && $stable(exp_out) && $stable(rounded_up))); // R11

endmodule

// File: tb/fp_round_unit_test.sv
module fp_round_unit_test;
  localparam int EW = 12;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] sig_in = '0;
  logic sticky_in = 1'b0, single_in = 1'b0, sign_in = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic [EW-1:0] exp_in = '0;
  logic [63:0] sig_out;
  logic [EW-1:0] exp_out;
  logic rounded_up, inexact, done;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fp_round_unit #(.EXP_W(EW)) uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [63:0] s, input logic st, input logic sg,
                         input logic [1:0] md, input logic sn, input logic [EW-1:0] e);
    int sh;
    logic [63:0] kept, rem, half, res;
    logic gt, eq, inx, up;
    logic [EW-1:0] eexp;
    sh   = sg ? 31 : 2;
    kept = s >> sh;
    rem  = s & ((64'd1 << sh) - 64'd1);
    half = 64'd1 << (sh - 1);
    inx  = (rem != 0) || st;
    gt   = (rem > half) || (rem == half && st);
    eq   = (rem == half) && !st;
    case (md)
      2'b00: up = gt || (eq && kept[0]);
      2'b01: up = 1'b0;
      2'b10: up = inx && !sn;
      default: up = inx && sn;
    endcase
    res  = (kept + {63'd0, up}) << sh;
    eexp = e;
    if (res[55]) begin res = res >> 1; eexp = e + 1'b1; end
    @(negedge clk);
    sig_in = s; sticky_in = st; single_in = sg; mode_in = md; sign_in = sn; exp_in = e; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 early", {63'd0, done}, 64'd0);
    @(negedge clk);
    chk("R10 done", {63'd0, done}, 64'd1);
    chk(sg ? "R2/R4/R5/R6/R7 sig" : "R1/R3/R5/R6/R7 sig", sig_out, res);
    chk("R9 exp", {{(64-EW){1'b0}}, exp_out}, {{(64-EW){1'b0}}, eexp});
    chk("R5/R6/R7 rounded_up", {63'd0, rounded_up}, {63'd0, up});
    chk("R8 inexact", {63'd0, inexact}, {63'd0, inx});
    sig_in = ~s; sticky_in = ~st; mode_in = ~md; exp_in = ~e; sign_in = ~sn;
    @(negedge clk);
    chk("R10 pulse", {63'd0, done}, 64'd0);
    chk("R11 hold sig", sig_out, res);
    chk("R11 hold exp", {{(64-EW){1'b0}}, exp_out}, {{(64-EW){1'b0}}, eexp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 sig", sig_out, 64'd0);
    chk("R12 flags", {61'd0, done, rounded_up, inexact}, 64'd0);
    rst_n = 1'b1;
    for (int b = 0; b < 2; b++)
      for (int sg = 0; sg < 2; sg++)
        for (int md = 0; md < 4; md++)
          for (int sn = 0; sn < 2; sn++)
            for (int p = 0; p < 16; p++)
              for (int st = 0; st < 2; st++)
                for (int ex = 0; ex < 2; ex++) begin
                  logic [63:0] s;
                  s = (b == 1) ? (64'h007F_FFFF_FFFF_FFFF & ~64'hF) : (64'h0040_0000_0000_0000 | 64'h0000_1234_0000_0000);
                  if (sg == 1) begin
                    s = s & ~(64'hF << 29);
                    s = s | (64'(p) << 29);
                    if (b == 1) s = s | (64'h1 << 31) | (64'h1 << 32);
                    if (ex == 1) s = s | (64'h1 << 10);
                  end else begin
                    s = s | 64'(p);
                    if (ex == 1) s = s | (64'h1 << 40);
                  end
                  run_one(s, st[0], sg[0], md[1:0], sn[0], EW'(12'h3F0 + p));
                end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule